// File: doc/BRIEF.md
# Supervisory Watchdog with Keyed Control Writes

This block supervises a processor by counting system clocks from the last restart. When the selected interval runs out it sets a timeout flag, which can raise an interrupt request. If the reset function is enabled, it also drives a system reset pulse once a fixed grace period has passed since the flag was set. Software keeps the watchdog quiet by restarting the count before the interval ends.

The bits that matter for safety are the restart command, the reset enable and the timeout flag. A control write changes them only when a two-write key sequence has just been written to a separate key register. Any other write, or a slow sequence, leaves them as they were. The interrupt enable and the interval select are not protected. Software reads the control register back through a read data port. The interval lengths are set by parameters: the base exponent defaults to 17 with a step of 3, which gives 2^17, 2^20, 2^23 or 2^26 clocks.

Top module: `wdt_guard`

## Requirements
- R1: The control register is written when `wr_sel`=0; its bits are bit0 restart (reads 0), bit1 reset enable, bit2 timeout flag, bit3 interrupt enable, bits 5:4 interval select, bit6 watchdog-reset cause (read only), and bit7, which reads 0. After a restart the timeout flag sets exactly 2^(BASE_LOG2 + STEP_LOG2*select) clocks later.
- R2: The timeout flag stays set until a keyed control write with bit2=0 clears it. Time passing, restarts and unkeyed writes leave it set.
- R3: A control write is keyed only if it comes straight after two writes to the key register (`wr_sel`=1): first 0xAA, then 0x55. No write of any kind may fall between them, and each step must come within KEY_WINDOW clocks of the one before it. A wrong value, the wrong order or a write in between breaks the sequence.
- R4: An unkeyed control write leaves restart, reset enable and the timeout flag unchanged, but it still updates the interrupt enable and the interval select.
- R5: `irq` is high exactly when the timeout flag, the interrupt enable and `gie` are all high.
- R6: With reset enabled, `sys_rst` rises GRACE_CYCLES clocks after the flag sets. With reset disabled, no reset occurs.
- R7: `sys_rst` stays high for exactly RST_PULSE clocks. The cause bit sets with it and stays set until `rst_n`.
- R8: A keyed restart during the grace period cancels the pending reset.
- R9: After `rst_n` the control register reads 0x00, and `irq` and `sys_rst` are low.
- R10: A keyed write is accepted up to KEY_WINDOW clocks after the 0x55 write. The clock after that, it is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the key register |
| wr_data | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| rd_data | output | 8 | Control register read value |
| irq | output | 1 | Watchdog interrupt request |
| sys_rst | output | 1 | System reset pulse |

## Verification
A counter that is off by even one clock moves the flag away from its exact expiry cycle. The interrupt and the reset pulse then move with it. So the bench samples on each side of every predicted edge. A key sequencer left open or opened wrongly shows at the next control write: `rd_data` bit1 or bit2 takes a value it should not have. A grace or pulse counter fault shows as a `sys_rst` edge moved by one or more clocks, a pulse of the wrong length, or a reset left after a cancelling restart. Each of these appears within one interval plus the grace period.

// File: rtl/wdt_pkg.sv
// Package: shared key values, control-bit positions and the key sequencer state type.
// Assumes: 8-bit register data.
package wdt_pkg;
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    localparam int CB_RESTART = 0;
    localparam int CB_RST_EN  = 1;
    localparam int CB_FLAG    = 2;
    localparam int CB_IE      = 3;
    localparam int CB_SEL_LO  = 4;
    localparam int CB_CAUSE   = 6;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_ARMED = 2'd1,
        UL_OPEN  = 2'd2
    } unlock_state_t;
endpackage

// File: rtl/wdt_unlock.sv
// Key sequencer: opens a short window after 0xAA then 0x55 are written to the key register.
// Assumes: any register write that is not the expected next step breaks the sequence.
module wdt_unlock
    import wdt_pkg::*;
#(
    parameter int WINDOW = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_key,
    input  logic [7:0] wr_data,
    output logic       unlock_ok
);
    localparam int WW = $clog2(WINDOW + 1);

    unlock_state_t  state;
    logic [WW-1:0]  win;

    // Advance the key sequence on writes; let the window run down when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= UL_IDLE;
            win   <= '0;
        end else if (wr_en) begin
            if (wr_key && wr_data == KEY_FIRST) begin
                state <= UL_ARMED;
                win   <= WW'(WINDOW);
            end else if (wr_key && wr_data == KEY_SECOND && state == UL_ARMED && win != '0) begin
                state <= UL_OPEN;
                win   <= WW'(WINDOW);
            end else begin
                state <= UL_IDLE;
                win   <= '0;
            end
        end else if (win != '0) begin
            win <= win - 1'b1;
        end else begin
            state <= UL_IDLE;
        end
    end

    assign unlock_ok = (state == UL_OPEN) && (win != '0);

    // R10: the window opens only straight after a 0x55 key write.
    a_r10_open_after_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        (state == UL_OPEN && $past(state) != UL_OPEN)
        |-> $past(wr_en && wr_key && wr_data == KEY_SECOND));

    // R3: the open state is reached only from the armed state.
    a_r3_open_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == UL_OPEN && $past(state) != UL_OPEN) |-> $past(state) == UL_ARMED);
endmodule

// File: rtl/wdt_interval.sv
// Interval counter: free-running clock count that is cleared by restart and ticks at the selected interval.
// Assumes: the select input is stable in the register; tick lasts one cycle each interval.
module wdt_interval #(
    parameter int BASE_LOG2 = 17,
    parameter int STEP_LOG2 = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MAXE = BASE_LOG2 + 3 * STEP_LOG2;

    logic [MAXE-1:0] cnt;
    logic [MAXE-1:0] mask [4];

    // One low-bit mask per interval choice.
    for (genvar g = 0; g < 4; g++) begin : g_mask
        assign mask[g] = {MAXE{1'b1}} >> (MAXE - (BASE_LOG2 + STEP_LOG2 * g));
    end

    // Count clocks since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = ((cnt & mask[sel]) == mask[sel]);

    // R1: a clear starts the interval from zero.
    a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt == '0);
endmodule

// File: rtl/wdt_reset_ctl.sv
// Reset timing: runs the grace period after a timeout and then drives a fixed-length reset pulse.
// Assumes: tick marks the cycle before the flag sets; restart cancels any pending grace period.
module wdt_reset_ctl #(
    parameter int GRACE = 512,
    parameter int PULSE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  logic rst_en,
    output logic fire,
    output logic sys_rst
);
    localparam int GW = (GRACE > 1) ? $clog2(GRACE) : 1;
    localparam int PW = $clog2(PULSE + 1);

    logic          grace_on;
    logic [GW-1:0] gcnt;
    logic [PW-1:0] pcnt;
    logic          grace_end;

    assign grace_end = grace_on && (gcnt == GW'(GRACE - 1));
    assign fire      = grace_end && rst_en;

    // Grace period: start on timeout, stop on restart or at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            grace_on <= 1'b0;
            gcnt     <= '0;
        end else if (grace_end) begin
            grace_on <= 1'b0;
            gcnt     <= '0;
        end else if (grace_on) begin
            gcnt <= gcnt + 1'b1;
        end else if (tick) begin
            grace_on <= 1'b1;
            gcnt     <= '0;
        end
    end

    // Reset pulse: registered, held for PULSE clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst <= 1'b0;
            pcnt    <= '0;
        end else if (fire) begin
            sys_rst <= 1'b1;
            pcnt    <= PW'(PULSE - 1);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end else begin
            sys_rst <= 1'b0;
        end
    end

    // R6: a reset pulse starts only while reset is enabled.
    a_r6_reset_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(rst_en));

    // R8: a restart leaves no grace period running.
    a_r8_restart_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !grace_on);
endmodule

// File: rtl/wdt_guard.sv
// Watchdog top: control register with keyed protection, interval counter, reset timing, interrupt request.
// Assumes: one register write per strobe; wr_sel picks control (0) or key (1) register.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2    = 17,
    parameter int STEP_LOG2    = 3,
    parameter int GRACE_CYCLES = 512,
    parameter int RST_PULSE    = 16,
    parameter int KEY_WINDOW   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       gie,
    output logic [7:0] rd_data,
    output logic       irq,
    output logic       sys_rst
);
    logic       unlock_ok;
    logic       ctrl_wr;
    logic       keyed_wr;
    logic       restart;
    logic       tick;
    logic       fire;
    logic       rst_en;
    logic       flag;
    logic       ie;
    logic [1:0] sel;
    logic       cause;
    logic       unused_bits;

    assign ctrl_wr     = wr_en && !wr_sel;
    assign keyed_wr    = ctrl_wr && unlock_ok;
    assign restart     = keyed_wr && wr_data[CB_RESTART];
    assign unused_bits = ^wr_data[7:6];

    wdt_unlock #(.WINDOW(KEY_WINDOW)) u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_key    (wr_sel),
        .wr_data   (wr_data),
        .unlock_ok (unlock_ok)
    );

    wdt_interval #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart || fire),
        .sel   (sel),
        .tick  (tick)
    );

    wdt_reset_ctl #(.GRACE(GRACE_CYCLES), .PULSE(RST_PULSE)) u_rstctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .rst_en  (rst_en),
        .fire    (fire),
        .sys_rst (sys_rst)
    );

    // Unprotected fields: any control write updates them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie  <= 1'b0;
            sel <= 2'd0;
        end else if (ctrl_wr) begin
            ie  <= wr_data[CB_IE];
            sel <= wr_data[CB_SEL_LO +: 2];
        end
    end

    // Protected fields: only keyed writes; timeout sets the flag first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_en <= 1'b0;
            flag   <= 1'b0;
        end else begin
            if (keyed_wr) rst_en <= wr_data[CB_RST_EN];
            if (tick)          flag <= 1'b1;
            else if (keyed_wr) flag <= wr_data[CB_FLAG];
        end
    end

    // Sticky reset cause, cleared only by rst_n.
    always_ff @(posedge clk) begin
        if (!rst_n)    cause <= 1'b0;
        else if (fire) cause <= 1'b1;
    end

    assign irq     = flag && ie && gie;
    assign rd_data = {1'b0, cause, sel, ie, flag, rst_en, 1'b0};

    // R4: an unkeyed control write keeps reset enable.
    a_r4_unkeyed_keeps_rsten: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !unlock_ok) |=> $stable(rst_en));

    // R2: the flag never drops without a keyed write.
    a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !keyed_wr) |=> flag);

    // R7: the cause bit is set whenever the reset pulse rises, and stays.
    a_r7_cause_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> cause);
    a_r7_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cause |=> cause);
endmodule

// File: tb/wdt_guard_test.sv
module wdt_guard_test;
    localparam int BASE  = 8;
    localparam int STEP  = 1;
    localparam int GRACE = 512;
    localparam int PULSE = 16;
    localparam int WIN   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       gie = 1'b0;
    logic [7:0] rd_data;
    logic       irq;
    logic       sys_rst;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    wdt_guard #(.BASE_LOG2(BASE), .STEP_LOG2(STEP), .GRACE_CYCLES(GRACE),
                .RST_PULSE(PULSE), .KEY_WINDOW(WIN)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .gie(gie), .rd_data(rd_data), .irq(irq), .sys_rst(sys_rst)
    );

    function automatic int interval_of(input logic [1:0] s);
        return 1 << (BASE + STEP * int'(s));
    endfunction

    function automatic logic irq_of(input logic f, input logic e, input logic g);
        return f & e & g;
    endfunction

    function automatic logic [7:0] ctrl_word(input logic [1:0] s, input logic e,
                                             input logic f, input logic ren, input logic rs);
        return {2'b00, s, e, f, ren, rs};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    // Caller sits at a negedge; the write lands on the next posedge.
    task automatic wr(input logic s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic keyed_wr(input logic [7:0] d);
        wr(1'b1, 8'hAA);
        wr(1'b1, 8'h55);
        wr(1'b0, d);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int p;
        int hi;
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        do_reset();

        // Reset state.
        chk("R9 rd_data", rd_data, 8'h00);
        chk("R9 irq", irq, 1'b0);
        chk("R9 sys_rst", sys_rst, 1'b0);

        // Unkeyed write: only interrupt enable sticks.
        wr(1'b0, 8'h0F);
        chk("R4 unkeyed write", rd_data, 8'h08);

        // Broken sequence: a control write between the keys.
        wr(1'b1, 8'hAA); wr(1'b0, 8'h00); wr(1'b1, 8'h55); wr(1'b0, 8'h02);
        chk("R3 interrupted sequence", rd_data, 8'h00);

        // Wrong order.
        wr(1'b1, 8'h55); wr(1'b1, 8'hAA); wr(1'b0, 8'h02);
        chk("R3 wrong order", rd_data, 8'h00);

        // Proper sequence.
        keyed_wr(8'h02);
        chk("R3 keyed write", rd_data, 8'h02);

        // Window edge: last accepted clock, then first rejected one.
        wr(1'b1, 8'hAA); wr(1'b1, 8'h55);
        repeat (WIN - 1) @(negedge clk);
        wr(1'b0, 8'h00);
        chk("R10 last window clock", rd_data, 8'h00);
        wr(1'b1, 8'hAA); wr(1'b1, 8'h55);
        repeat (WIN) @(negedge clk);
        wr(1'b0, 8'h02);
        chk("R10 window closed", rd_data, 8'h00);

        // Flag sticky, interrupt gating.
        do_reset();
        keyed_wr(ctrl_word(2'd0, 1'b0, 1'b0, 1'b0, 1'b1));
        p = interval_of(2'd0);
        repeat (p - 1) @(negedge clk);
        chk("R1 flag before expiry", rd_data[2], 1'b0);
        @(negedge clk);
        chk("R1 flag at expiry", rd_data[2], 1'b1);
        wr(1'b0, 8'h08);
        chk("R2 unkeyed clear ignored", rd_data, 8'h0C);
        chk("R5 gie low", irq, 1'b0);
        gie = 1'b1; #1;
        chk("R5 all set", irq, 1'b1);
        repeat (300) @(negedge clk);
        chk("R2 flag held", rd_data[2], 1'b1);
        keyed_wr(8'h00);
        chk("R2 keyed clear", rd_data[2], 1'b0);
        chk("R5 flag clear", irq, 1'b0);
        gie = 1'b0;

        // Restart inside the grace period cancels the reset.
        do_reset();
        keyed_wr(ctrl_word(2'd0, 1'b0, 1'b0, 1'b1, 1'b1));
        repeat (interval_of(2'd0) + 100) @(negedge clk);
        keyed_wr(ctrl_word(2'd0, 1'b0, 1'b1, 1'b1, 1'b1));
        hi = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (sys_rst) hi++;
        end
        chk("R8 no reset after restart", hi, 0);
        chk("R8 cause clear", rd_data[6], 1'b0);

        // Random configurations.
        for (int it = 0; it < 8; it++) begin
            logic [1:0] s;
            logic en, e, g;
            s  = 2'($urandom % 4);
            en = 1'($urandom % 2);
            e  = 1'($urandom % 2);
            g  = 1'($urandom % 2);
            if (it == 0) en = 1'b1;
            if (it == 1) en = 1'b0;
            do_reset();
            gie = g;
            keyed_wr(ctrl_word(s, e, 1'b0, en, 1'b1));
            p = interval_of(s);
            repeat (p - 1) @(negedge clk);
            chk("R1 random before expiry", rd_data[2], 1'b0);
            @(negedge clk);
            chk("R1 random at expiry", rd_data[2], 1'b1);
            chk("R5 random irq", irq, irq_of(1'b1, e, g));
            gie = ~g; #1;
            chk("R5 random gie flip", irq, irq_of(1'b1, e, ~g));
            if (en) begin
                repeat (GRACE - 1) @(negedge clk);
                chk("R6 before grace end", sys_rst, 1'b0);
                @(negedge clk);
                chk("R6 reset at grace end", sys_rst, 1'b1);
                repeat (PULSE - 1) @(negedge clk);
                chk("R7 pulse last clock", sys_rst, 1'b1);
                @(negedge clk);
                chk("R7 pulse ended", sys_rst, 1'b0);
                chk("R7 cause set", rd_data[6], 1'b1);
            end else begin
                hi = 0;
                for (int k = 0; k < GRACE + PULSE + 8; k++) begin
                    @(negedge clk);
                    if (sys_rst) hi++;
                end
                chk("R6 disabled no reset", hi, 0);
                chk("R6 disabled cause clear", rd_data[6], 1'b0);
            end
        end
        finish_run();
    end
endmodule